// File: doc/BRIEF.md
# Ramped Stereo Gain Stage with Mutes

This block sits in a two-channel audio output path and scales each signed 16-bit sample by a 9-bit gain. The gain runs from 0 to 256, and 256 means unity. The gain does not jump when the requested level changes. An internal gain counter moves one unit toward its target once every four sample periods. A change of target during a ramp redirects the counter from where it stands, so the ramp does not restart and no step is audible.

The target is the 8-bit attenuation level when attenuation is enabled, and unity when it is disabled. Soft mute walks the gain down to zero at the same step rate. Releasing soft mute snaps the gain straight to the target. Forced muting zeroes the output. It can be requested by a flag, by a pin, or by the memory-empty condition while the memory path is active. Forced muting takes effect and clears only at a left-channel word. The gain also changes only at a left-channel word, so the two samples of a stereo pair always carry the same gain and mute state.

Samples arrive with a strobe and a left/right indicator. A sample period is counted as one left-channel strobe.

Top module: `gain_ramp_atten`

## Requirements
- R1: Each input strobe produces exactly one registered output strobe on the next clock, with the same left/right indicator. Without an input strobe, out_valid is low.
- R2: Output data equals the signed input times the current gain (0..256), shifted right arithmetically by 8, which rounds toward negative infinity. For example, -1 at gain 128 gives -1, and -3 at gain 128 gives -2.
- R3: After synchronous reset, out_valid and out_data are 0, the gain counter holds 256 (unity), and no mute is active.
- R4: With att_en low the target is 256. With att_en high the target is att_level (0..255).
- R5: Outside the soft-mute release, the gain changes by at most one unit per step. A step happens only on every fourth left-channel strobe counted from reset.
- R6: When the target changes mid-ramp, the gain continues from its current value toward the newest target.
- R7: While soft_mute is high, the gain decreases by one every fourth left strobe until it reaches 0. From unity this takes 1024 sample periods.
- R8: At the first left strobe after soft_mute falls, the gain is set directly to the target. That left sample and the rest of its pair use the new gain.
- R9: Forced mute is the OR of mute_flag and mute_pin. It is sampled only on a left strobe and applies from that left sample until the next left strobe. While it applies, out_data is 0.
- R10: mem_on and mem_empty both high acts as a forced-mute request, with the same left-word alignment. mem_empty with mem_on low has no effect.
- R11: The gain is updated only on a left strobe and applies from that left sample onward, so a left/right pair shares one gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_left | input | 1 | 1 = left-channel sample |
| smp_data | input | 16 | Signed input sample |
| att_level | input | 8 | Attenuation level, gain = level/256 |
| att_en | input | 1 | Attenuation enable |
| soft_mute | input | 1 | Soft (ramped) mute request |
| mute_flag | input | 1 | Forced mute request (register) |
| mute_pin | input | 1 | Forced mute request (pin) |
| mem_on | input | 1 | Memory path active |
| mem_empty | input | 1 | No valid data in memory |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 1 | 1 = left-channel output |
| out_data | output | 16 | Scaled signed output sample |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Rounding of negative samples:** a design that rounds toward zero returns 0 instead of -1 for small negative inputs.
- **Mute changes mid-pair:** a forced mute raised or dropped between the left and right word must not touch the right word. A design that mutes immediately would zero a lone right sample.
- **Soft-mute duration and release:** a design with the wrong step divider reaches zero early. A design that ramps on release, instead of jumping, shows the old gain after release.
- **Retargeting mid-ramp and memory-empty gating:** retargeting must continue from the current gain. A design that ignores mem_on would mute on mem_empty alone.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int DATA_W = 16;
  localparam int ATT_W  = 8;
  localparam int GAIN_W = ATT_W + 1;
  localparam int PRE_W  = 2;

  // Effective gain target: unity when disabled, level when enabled.
  function automatic logic [GAIN_W-1:0] gain_target(input logic en,
                                                   input logic [ATT_W-1:0] lvl);
    gain_target = en ? {1'b0, lvl} : GAIN_W'(1 << ATT_W);
  endfunction
endpackage

// File: rtl/atten_gain_step.sv
module atten_gain_step #(
  parameter int ATT_W = 8,
  parameter int PRE_W = 2,
  localparam int GAIN_W = ATT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              soft_mute,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain_q,
  output logic [GAIN_W-1:0] gain_nxt,
  output logic              soft_q
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << ATT_W);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = &pre_q;

  always_comb begin
    gain_nxt = gain_q;
    if (step_en) begin
      if (soft_mute) begin
        if (tick && gain_q != '0) gain_nxt = gain_q - 1'b1;
      end else if (soft_q) begin
        gain_nxt = target;
      end else if (tick) begin
        if (gain_q < target)      gain_nxt = gain_q + 1'b1;
        else if (gain_q > target) gain_nxt = gain_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= UNITY;
      pre_q  <= '0;
      soft_q <= 1'b0;
    end else if (step_en) begin
      gain_q <= gain_nxt;
      pre_q  <= pre_q + 1'b1;
      soft_q <= soft_mute;
    end
  end
endmodule

// File: rtl/atten_mute_align.sv
module atten_mute_align (
  input  logic clk,
  input  logic rst,
  input  logic left_stb,
  input  logic mute_req,
  output logic mute_q,
  output logic mute_nxt
);
  assign mute_nxt = left_stb ? mute_req : mute_q;

  always_ff @(posedge clk) begin
    if (rst) mute_q <= 1'b0;
    else     mute_q <= mute_nxt;
  end
endmodule

// File: rtl/atten_scaler.sv
module atten_scaler #(
  parameter int DATA_W = 16,
  parameter int ATT_W  = 8,
  localparam int GAIN_W = ATT_W + 1,
  localparam int PROD_W = DATA_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_left,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [GAIN_W-1:0]        gain,
  input  logic                     mute,
  output logic                     out_valid,
  output logic                     out_left,
  output logic signed [DATA_W-1:0] out_data
);
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  assign prod    = PROD_W'(in_data) * PROD_W'($signed({1'b0, gain}));
  assign shifted = prod >>> ATT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_left  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left <= in_left;
        out_data <= mute ? '0 : shifted[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gain_ramp_atten.sv
module gain_ramp_atten #(
  parameter int DATA_W = atten_pkg::DATA_W,
  parameter int ATT_W  = atten_pkg::ATT_W,
  parameter int PRE_W  = atten_pkg::PRE_W,
  localparam int GAIN_W = ATT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic                     smp_left,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic [ATT_W-1:0]         att_level,
  input  logic                     att_en,
  input  logic                     soft_mute,
  input  logic                     mute_flag,
  input  logic                     mute_pin,
  input  logic                     mem_on,
  input  logic                     mem_empty,
  output logic                     out_valid,
  output logic                     out_left,
  output logic signed [DATA_W-1:0] out_data
);
  logic              left_stb;
  logic [GAIN_W-1:0] tgt;
  logic [GAIN_W-1:0] gain_q, gain_nxt, gain_use;
  logic              soft_q;
  logic              mute_req, mute_q, mute_nxt;

  assign left_stb = smp_valid && smp_left;
  assign tgt      = atten_pkg::gain_target(att_en, att_level);
  assign mute_req = mute_flag || mute_pin || (mem_on && mem_empty);
  assign gain_use = left_stb ? gain_nxt : gain_q;

  atten_gain_step #(.ATT_W(ATT_W), .PRE_W(PRE_W)) u_step (
    .clk(clk), .rst(rst), .step_en(left_stb), .soft_mute(soft_mute),
    .target(tgt), .gain_q(gain_q), .gain_nxt(gain_nxt), .soft_q(soft_q)
  );

  atten_mute_align u_mute (
    .clk(clk), .rst(rst), .left_stb(left_stb), .mute_req(mute_req),
    .mute_q(mute_q), .mute_nxt(mute_nxt)
  );

  atten_scaler #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_scale (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_left(smp_left),
    .in_data(smp_data), .gain(gain_use), .mute(mute_nxt),
    .out_valid(out_valid), .out_left(out_left), .out_data(out_data)
  );
endmodule

// File: rtl/atten_checker.sv
module atten_checker #(
  parameter int DATA_W = 16,
  parameter int ATT_W  = 8,
  localparam int GAIN_W = ATT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic              smp_left,
  input logic              soft_mute,
  input logic              mem_on,
  input logic              mem_empty,
  input logic              out_valid,
  input logic              out_left,
  input logic [DATA_W-1:0] out_data,
  input logic [GAIN_W-1:0] gain_q,
  input logic [GAIN_W-1:0] tgt,
  input logic              soft_q,
  input logic              mute_q,
  input logic              mute_nxt
);
  localparam int UNITY = 1 << ATT_W;

  assert_valid_R1: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid && (out_left == $past(smp_left)));
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !out_valid);
  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(gain_q) <= UNITY);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && smp_left) |=> $stable(gain_q));
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_left && !(soft_q && !soft_mute)) |=>
      (int'(gain_q) <= int'($past(gain_q)) + 1) && (int'(gain_q) + 1 >= int'($past(gain_q))));
  assert_soft_down_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_left && soft_mute) |=> int'(gain_q) <= int'($past(gain_q)));
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_left && soft_q && !soft_mute) |=> gain_q == $past(tgt));
  assert_mute_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && smp_left) |=> $stable(mute_q));
  assert_mute_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mute_nxt) |=> out_data == '0);
  assert_mem_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_left && mem_on && mem_empty) |=> out_data == '0);
endmodule

bind gain_ramp_atten atten_checker #(.DATA_W(DATA_W), .ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
  .soft_mute(soft_mute), .mem_on(mem_on), .mem_empty(mem_empty),
  .out_valid(out_valid), .out_left(out_left), .out_data(out_data),
  .gain_q(gain_q), .tgt(tgt), .soft_q(soft_q), .mute_q(mute_q),
  .mute_nxt(mute_nxt)
);

// File: tb/sim_gain_ramp_atten.sv
module sim_gain_ramp_atten;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, smp_left = 1'b0;
  logic signed [15:0] smp_data = '0;
  logic [7:0] att_level = 8'd64;
  logic att_en = 1'b0, soft_mute = 1'b0, mute_flag = 1'b0, mute_pin = 1'b0;
  logic mem_on = 1'b0, mem_empty = 1'b0;
  logic out_valid, out_left;
  logic signed [15:0] out_data;

  int n_checks = 0, n_fail = 0;
  bit  done = 0;

  // Bench model state
  int m_gain = 256, m_cnt = 0, m_fm = 0;
  bit m_softq = 0;

  always #2.5 clk = ~clk;

  gain_ramp_atten u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_data(smp_data), .att_level(att_level), .att_en(att_en),
    .soft_mute(soft_mute), .mute_flag(mute_flag), .mute_pin(mute_pin),
    .mem_on(mem_on), .mem_empty(mem_empty), .out_valid(out_valid),
    .out_left(out_left), .out_data(out_data)
  );

  function automatic int scale_exp(int d, int g, int fm);
    int p;
    p = d * g;
    if (fm != 0) return 0;
    return p >>> 8;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_left();
    int tgt;
    tgt = att_en ? int'(att_level) : 256;
    if (soft_mute) begin
      if (m_cnt == 3 && m_gain > 0) m_gain--;
    end else if (m_softq) begin
      m_gain = tgt;
    end else if (m_cnt == 3) begin
      if (m_gain < tgt) m_gain++;
      else if (m_gain > tgt) m_gain--;
    end
    m_softq = soft_mute;
    m_cnt = (m_cnt + 1) % 4;
    m_fm = (mute_flag || mute_pin || (mem_on && mem_empty)) ? 1 : 0;
  endfunction

  // Send one sample, check the registered output; returns output data.
  task automatic strobe(string tag, bit left, int d, output int got);
    int exp;
    @(negedge clk);
    smp_valid = 1'b1; smp_left = left; smp_data = 16'(d);
    if (left) model_left();
    exp = scale_exp(d, m_gain, m_fm);
    @(negedge clk);
    smp_valid = 1'b0;
    check({tag, " valid/R1"}, int'(out_valid), 1);
    check({tag, " side/R1"}, int'(out_left), int'(left));
    check(tag, int'(out_data), exp);
    got = int'(out_data);
  endtask

  task automatic pair(string tag);
    int g;
    strobe(tag, 1'b1, $signed(16'($urandom)), g);
    strobe(tag, 1'b0, $signed(16'($urandom)), g);
  endtask

  task automatic probe(string tag, output int g);
    int r;
    strobe(tag, 1'b1, 256, g);
    strobe(tag, 1'b0, 256, r);
    check({tag, " pair/R11"}, r, g);
  endtask

  initial begin
    int g, r;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R3 out_valid", int'(out_valid), 0);
    check("R3 out_data", int'(out_data), 0);
    rst = 1'b0;

    // Unity after reset, enable off
    strobe("R3", 1'b1, 12345, g); check("R4 unity", g, 12345);
    strobe("R4", 1'b0, -2222, g); check("R4 unity", g, -2222);
    repeat (6) pair("R4");

    // Ramp down to 128, then rounding corners
    att_en = 1'b1; att_level = 8'd128;
    while (m_gain != 128) pair("R5");
    probe("R5 settle", g); check("R5 settle", g, 128);
    strobe("R2", 1'b1, -1, g); check("R2 neg", g, -1);
    strobe("R2", 1'b0, -3, g); check("R2 neg", g, -2);
    strobe("R2", 1'b1, 3, g);  check("R2 pos", g, 1);
    strobe("R2", 1'b0, -32768, g); check("R2 min", g, -16384);

    // Retarget mid-ramp
    att_level = 8'd200;
    repeat (40) pair("R6");
    probe("R6 mid", g); check("R6 mid above", int'(g > 128 && g < 200), 1);
    att_level = 8'd100;
    repeat (8) pair("R6");
    probe("R6 turn", g); check("R6 continues", int'(g > 100 && g < 200), 1);
    while (m_gain != 100) pair("R6");
    probe("R6 final", g); check("R6 final", g, 100);

    // Disable: ramp back to unity
    att_en = 1'b0;
    while (m_gain != 256) pair("R4");
    probe("R4 unity", g); check("R4 back", g, 256);

    // Soft mute from unity
    soft_mute = 1'b1;
    repeat (1000) pair("R7");
    probe("R7 not yet", g); check("R7 not yet zero", int'(g > 0), 1);
    repeat (40) pair("R7");
    probe("R7 zero", g); check("R7 zero", g, 0);

    // Release jumps to target
    att_en = 1'b1; att_level = 8'd64;
    soft_mute = 1'b0;
    probe("R8 jump", g); check("R8 jump", g, 64);

    // Forced mute flag raised mid-pair
    strobe("R9", 1'b1, 4000, g);
    mute_flag = 1'b1;
    strobe("R9", 1'b0, 4000, g); check("R9 right untouched", g, 1000);
    strobe("R9", 1'b1, 4000, g); check("R9 muted", g, 0);
    mute_flag = 1'b0;
    strobe("R9", 1'b0, 4000, g); check("R9 still muted", g, 0);
    strobe("R9", 1'b1, 4000, g); check("R9 released", g, 1000);
    mute_pin = 1'b1;
    strobe("R9", 1'b0, 4000, g); check("R9 pin mid", g, 1000);
    strobe("R9", 1'b1, 4000, g); check("R9 pin", g, 0);
    mute_pin = 1'b0;
    strobe("R9", 1'b0, 4000, g);

    // Memory empty
    mem_empty = 1'b1;
    probe("R10 off", r); check("R10 no effect", r, 64);
    mem_on = 1'b1;
    strobe("R10", 1'b1, 4000, g); check("R10 empty mute", g, 0);
    mem_empty = 1'b0;
    strobe("R10", 1'b0, 4000, g); check("R10 held", g, 0);
    strobe("R10", 1'b1, 4000, g); check("R10 released", g, 1000);
    strobe("R10", 1'b0, 4000, g);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 19) == 0) att_level = 8'($urandom);
      if ($urandom_range(0, 39) == 0) att_en = ~att_en;
      if ($urandom_range(0, 59) == 0) soft_mute = ~soft_mute;
      mute_flag = ($urandom_range(0, 15) == 0);
      mute_pin  = ($urandom_range(0, 25) == 0);
      mem_empty = ($urandom_range(0, 20) == 0);
      strobe("R11 rand", 1'b1, $signed(16'($urandom)), g);
      if ($urandom_range(0, 3) == 0) begin
        mute_flag = ~mute_flag; att_level = 8'($urandom); soft_mute = ~soft_mute;
      end
      strobe("R11 rand", 1'b0, $signed(16'($urandom)), g);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule